// File: doc/BRIEF.md
# External Event Rendezvous Channel

This block couples one asynchronous external request line to a single waiting process inside the core. The raw request passes through a multi-flop synchroniser. It is then rising-edge detected, and the detected edge is the event. A process claims the channel through a bind port, and at most one process can hold it at a time. When an event meets a bound process, the block counts a fixed number of cycles and then issues a one-cycle schedule strobe that carries the owner's identifier. At the same time it raises the acknowledge line, which stays high until the external side drops its request. This closes a four-phase handshake, and the channel then falls back to idle with the binding released.

The fixed delay models the event being serviced in place of the next instruction rather than the current one. If an event arrives while nobody is bound, it is held as pending. The next process to bind then consumes it at once, unless software discards it first with a clear pulse. A bound process that no longer wants the event can withdraw with a cancel pulse, as long as no event has yet been taken.

Top module: `event_rendezvous`

## Requirements
- R1: After reset, ext_ack_o, sched_stb_o and bind_nak_o are low, no process is bound and no event is pending.
- R2: With a process bound and waiting, the request going high produces a one-cycle sched_stb_o pulse. The pulse rises on the (SYNC_STAGES+LATENCY)-th rising clock edge after the request rises, and sched_stb_o stays low on every edge before that.
- R3: ext_ack_o rises in the same cycle as sched_stb_o and stays high while the request is held. It falls on the (SYNC_STAGES+1)-th rising edge after the request falls, which completes the four-phase handshake.
- R4: While sched_stb_o is high, sched_pid_o equals the identifier that was presented on bind_pid_i when the binding was accepted.
- R5: A bind attempt made while the channel is owned (waiting, counting or acknowledging) is refused. bind_nak_o is high for exactly the cycle after the attempt, and the original owner's identifier is the one scheduled.
- R6: With no process bound, ext_ack_o and sched_stb_o stay low whatever the request does, and a request edge is latched as pending.
- R7: A bind accepted while an event is pending raises sched_stb_o on the LATENCY-th rising edge, counting the edge that samples the bind as the first. This consumes the pending event, so the next binding waits for a fresh request edge.
- R8: A pend_clr_i pulse while unbound discards a pending event, so a later bind produces no strobe until a new request edge arrives.
- R9: A cancel_i pulse while bound and waiting releases the binding. A later request edge then gives no acknowledge and is latched as pending, and the next bind is accepted without bind_nak_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_req_i | input | 1 | Asynchronous external event request |
| ext_ack_o | output | 1 | Acknowledge to the external requester |
| bind_valid_i | input | 1 | A process asks to wait on the channel |
| bind_pid_i | input | PID_W | Identifier of the process asking to bind |
| cancel_i | input | 1 | Bound process withdraws before an event is taken |
| pend_clr_i | input | 1 | Discard an event latched while unbound |
| bind_nak_o | output | 1 | One-cycle refusal of a bind attempt |
| sched_stb_o | output | 1 | One-cycle strobe: schedule the owner now |
| sched_pid_o | output | PID_W | Identifier of the process to schedule |

## Verification
Two situations are hard to reach from the ports. The first is a refused bind, which needs a second bind attempt while a first owner is still counting or already acknowledging. The bench issues one bind straight after another, and it issues a further bind while it holds the request high during acknowledge. The second is a pending event. The bench produces one by pulsing the request with nobody bound, and then checks it indirectly: a later bind must yield a strobe after exactly LATENCY edges, or no strobe at all after a clear or once the event has been consumed. The basic handshake is swept over every identifier value and several request hold lengths.

// File: rtl/evt_chan_pkg.sv
package evt_chan_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_WAIT  = 2'd2,
        CH_ACK   = 2'd3
    } ch_state_e;

    typedef struct packed {
        ch_state_e st;
        logic      pend;
        logic      stb;
        logic      nak;
    } ch_regs_t;

endpackage

// File: rtl/evt_req_sync.sv
module evt_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/evt_lat_timer.sv
module evt_lat_timer #(
    parameter int LATENCY = 19
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic expire_o
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)               cnt_d = CW'(LATENCY - 1);
        else if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // high in the last counting cycle; the owner registers the strobe on the next edge
    assign expire_o = (cnt_q == CW'(1));
endmodule

// File: rtl/event_rendezvous.sv
module event_rendezvous #(
    parameter int PID_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int LATENCY     = 19   // must be at least 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ext_req_i,
    output logic             ext_ack_o,
    input  logic             bind_valid_i,
    input  logic [PID_W-1:0] bind_pid_i,
    input  logic             cancel_i,
    input  logic             pend_clr_i,
    output logic             bind_nak_o,
    output logic             sched_stb_o,
    output logic [PID_W-1:0] sched_pid_o
);
    import evt_chan_pkg::*;

    logic req_level, req_rise;
    logic tmr_start, tmr_expire;
    logic wait_now;

    ch_regs_t         r_d, r_q;
    logic [PID_W-1:0] owner_d, owner_q;

    evt_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ext_req_i),
        .level_o (req_level),
        .rise_o  (req_rise)
    );

    evt_lat_timer #(.LATENCY(LATENCY)) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (tmr_start),
        .expire_o (tmr_expire)
    );

    always_comb begin
        r_d       = r_q;
        r_d.stb   = 1'b0;
        r_d.nak   = 1'b0;
        owner_d   = owner_q;
        tmr_start = 1'b0;
        unique case (r_q.st)
            CH_IDLE: begin
                if (bind_valid_i) begin
                    owner_d = bind_pid_i;
                    if (r_q.pend || req_rise) begin
                        r_d.st    = CH_WAIT;
                        r_d.pend  = 1'b0;
                        tmr_start = 1'b1;
                    end else begin
                        r_d.st = CH_ARMED;
                    end
                end else if (req_rise) begin
                    r_d.pend = 1'b1;
                end else if (pend_clr_i) begin
                    r_d.pend = 1'b0;
                end
            end
            CH_ARMED: begin
                r_d.nak = bind_valid_i;
                if (req_rise) begin
                    r_d.st    = CH_WAIT;
                    tmr_start = 1'b1;
                end else if (cancel_i) begin
                    r_d.st = CH_IDLE;
                end
            end
            CH_WAIT: begin
                r_d.nak = bind_valid_i;
                if (tmr_expire) begin
                    r_d.st  = CH_ACK;
                    r_d.stb = 1'b1;
                end
            end
            CH_ACK: begin
                r_d.nak = bind_valid_i;
                if (!req_level) r_d.st = CH_IDLE;
            end
            default: r_d.st = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q     <= '{st: CH_IDLE, pend: 1'b0, stb: 1'b0, nak: 1'b0};
            owner_q <= '0;
        end else begin
            r_q     <= r_d;
            owner_q <= owner_d;
        end
    end

    assign wait_now    = (r_q.st == CH_WAIT);
    assign ext_ack_o   = (r_q.st == CH_ACK);
    assign sched_stb_o = r_q.stb;
    assign bind_nak_o  = r_q.nak;
    assign sched_pid_o = owner_q;
endmodule

// File: rtl/event_rendezvous_chk.sv
module event_rendezvous_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic ext_ack_o,
    input logic bind_valid_i,
    input logic bind_nak_o,
    input logic sched_stb_o,
    input logic req_level,
    input logic wait_now
);
    // R3
    stb_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sched_stb_o |-> ext_ack_o);

    // R3
    ack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ext_ack_o) |-> sched_stb_o);

    // R3
    ack_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ext_ack_o) |-> !$past(req_level));

    // R2
    stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sched_stb_o |=> !sched_stb_o);

    // R2
    stb_after_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sched_stb_o) |-> $past(wait_now));

    // R5
    nak_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bind_nak_o |-> $past(bind_valid_i));
endmodule

bind event_rendezvous event_rendezvous_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ext_ack_o    (ext_ack_o),
    .bind_valid_i (bind_valid_i),
    .bind_nak_o   (bind_nak_o),
    .sched_stb_o  (sched_stb_o),
    .req_level    (req_level),
    .wait_now     (wait_now)
);

// File: tb/event_rendezvous_tb.sv
`timescale 1ns/1ps
module event_rendezvous_tb;
    localparam int PID_W = 4;
    localparam int SYNC  = 2;
    localparam int LAT   = 19;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ext_req = 1'b0;
    logic             ext_ack;
    logic             bind_valid = 1'b0;
    logic [PID_W-1:0] bind_pid = '0;
    logic             cancel = 1'b0;
    logic             pend_clr = 1'b0;
    logic             bind_nak;
    logic             sched_stb;
    logic [PID_W-1:0] sched_pid;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    event_rendezvous #(.PID_W(PID_W), .SYNC_STAGES(SYNC), .LATENCY(LAT)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .ext_req_i(ext_req), .ext_ack_o(ext_ack),
        .bind_valid_i(bind_valid), .bind_pid_i(bind_pid), .cancel_i(cancel),
        .pend_clr_i(pend_clr), .bind_nak_o(bind_nak), .sched_stb_o(sched_stb),
        .sched_pid_o(sched_pid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_bind(input int pid, output int nak);
        bind_valid = 1'b1;
        bind_pid   = PID_W'(pid);
        @(posedge clk);
        @(negedge clk);
        bind_valid = 1'b0;
        nak = int'(bind_nak);
    endtask

    task automatic pulse_cancel();
        cancel = 1'b1;
        @(posedge clk); @(negedge clk);
        cancel = 1'b0;
    endtask

    task automatic pulse_clr();
        pend_clr = 1'b1;
        @(posedge clk); @(negedge clk);
        pend_clr = 1'b0;
    endtask

    task automatic watch(input int n, output int stbs, output int acks);
        stbs = 0; acks = 0;
        repeat (n) begin
            @(posedge clk); @(negedge clk);
            stbs += int'(sched_stb);
            acks += int'(ext_ack);
        end
    endtask

    // request high now; check strobe timing, identifier, hold, release
    task automatic handshake(input int pid, input int hold, input int nak_try);
        int nk;
        ext_req = 1'b1;
        repeat (SYNC + LAT - 1) @(posedge clk);
        @(negedge clk);
        chk("R2 strobe early", int'(sched_stb), 0);
        @(posedge clk); @(negedge clk);
        chk("R2 strobe on time", int'(sched_stb), 1);
        chk("R3 ack with strobe", int'(ext_ack), 1);
        chk("R4 identifier", int'(sched_pid), pid);
        for (int h = 0; h < hold; h++) begin
            @(posedge clk); @(negedge clk);
            chk("R3 ack held", int'(ext_ack), 1);
            chk("R2 strobe single", int'(sched_stb), 0);
        end
        if (nak_try != 0) begin
            do_bind(14, nk);
            chk("R5 refused during ack", nk, 1);
        end
        ext_req = 1'b0;
        repeat (SYNC) @(posedge clk);
        @(negedge clk);
        chk("R3 ack before release", int'(ext_ack), 1);
        @(posedge clk); @(negedge clk);
        chk("R3 ack released", int'(ext_ack), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int nk, s, a;
        repeat (3) @(negedge clk);
        chk("R1 ack reset", int'(ext_ack), 0);
        chk("R1 strobe reset", int'(sched_stb), 0);
        chk("R1 nak reset", int'(bind_nak), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep every identifier and several hold lengths
        for (int p = 0; p < (1 << PID_W); p++) begin
            do_bind(p, nk);
            chk("R5 bind accepted when idle", nk, 0);
            handshake(p, p % 4, 0);
        end

        // R5: second bind refused while armed, and while acknowledging
        do_bind(3, nk);
        chk("R5 first bind", nk, 0);
        do_bind(5, nk);
        chk("R5 second bind refused", nk, 1);
        @(negedge clk);
        chk("R5 nak single cycle", int'(bind_nak), 0);
        handshake(3, 2, 1);

        // R6: no owner, request pulse gives no acknowledge
        ext_req = 1'b1;
        watch(4, s, a);
        ext_req = 1'b0;
        chk("R6 no ack unbound", a, 0);
        watch(LAT + 6, s, a);
        chk("R6 no ack unbound later", a, 0);
        chk("R6 no strobe unbound", s, 0);

        // R7: bind consumes pending event after LATENCY edges
        do_bind(7, nk);
        chk("R7 bind accepted", nk, 0);
        repeat (LAT - 2) @(posedge clk);
        @(negedge clk);
        chk("R7 strobe early", int'(sched_stb), 0);
        @(posedge clk); @(negedge clk);
        chk("R7 strobe on time", int'(sched_stb), 1);
        chk("R7 identifier", int'(sched_pid), 7);
        @(posedge clk); @(negedge clk);
        chk("R7 ack drops with request low", int'(ext_ack), 0);
        do_bind(8, nk);
        watch(LAT + 5, s, a);
        chk("R7 pending consumed", s, 0);
        pulse_cancel();

        // R8: cleared pending gives no strobe
        ext_req = 1'b1;
        watch(4, s, a);
        ext_req = 1'b0;
        watch(4, s, a);
        pulse_clr();
        do_bind(9, nk);
        chk("R8 bind accepted", nk, 0);
        watch(LAT + 5, s, a);
        chk("R8 cleared pending ignored", s, 0);
        pulse_cancel();

        // R9: cancel releases the binding
        do_bind(10, nk);
        pulse_cancel();
        ext_req = 1'b1;
        watch(4, s, a);
        ext_req = 1'b0;
        watch(LAT + 6, s, a);
        chk("R9 no ack after cancel", a + s, 0);
        do_bind(11, nk);
        chk("R9 rebind accepted", nk, 0);
        watch(LAT - 1, s, a);
        chk("R9 pending served", s, 1);
        chk("R9 ack pulse", a, 1);
        watch(3, s, a);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule